// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits beside an 8-bit processor with a 16-bit address bus and a valid-address / enable / read-write bus. It turns each bus address into one device select. The 64 KB space is first cut into thirty-two 2 KB blocks using the top five address bits. Those blocks are grouped into RAM, two ROMs, a reserved area and a single I/O block. Inside the I/O block, a second decode level produces one-hot clock strobes for peripherals. These include a 16-entry page of strobes with one strobe per address, and that page repeats in every 256-byte sub-page of the I/O block.

An access is qualified only when VMA and E are both high. Every output is registered. An access presented at a rising clock edge appears on the outputs during the following cycle. An unqualified access leaves every output low.

The RAM enables come from one flop that holds the read/write direction and is used with both polarities. A qualified access that matches no device raises `no_dev`, so a stray pointer can be caught.

Top module: `mmio_addr_decode`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is low.
- R2: Every output is registered. Outputs in cycle n+1 reflect `addr`, `vma`, `e` and `rw` sampled at the rising edge that ends cycle n. If `vma` and `e` were not both high at that edge, every output is low.
- R3: A qualified access in 8000–9FFF, or in its alias 0000–07FF, selects RAM. `ram_oe` is raised when `rw` is 1 (read) and `ram_we` when `rw` is 0 (write).
- R4: A qualified access in A000–BFFF, or in its alias 1000–1FFF, raises `rom0_cs`. An access in C000–FFFF raises `rom1_cs`.
- R5: A qualified access in 2000–7FFF raises only `no_dev`.
- R6: In 0800–085F the 16-byte slot number `addr[7:4]` selects a control strobe, as follows:
  - slot 0 raises `ctl_stb[0]`.
  - slot 1 raises `ctl_stb[1]`.
  - slot 2 raises `ctl_stb[2]`, but only for 0820–0823; 0824–082F is treated as undecoded.
  - slots 3, 4 and 5 raise `ctl_stb[3]`, `ctl_stb[4]` and `ctl_stb[5]` (the three demultiplexer-on strobes).
- R7: The slots at 0860, 0960 and 0A60 raise `ctl_stb[6]`, `ctl_stb[7]` and `ctl_stb[8]` (the demultiplexer-off strobes).
- R8: For any high byte 08 to 0F, addresses xx70–xx7F raise `page_stb[addr[3:0]]`. The bit order is: DAC high byte, DAC low byte, port 1, port 2, port 3, readout 1, readout 2, display sequencer, attenuator, channel 2 preamp, channel 1 preamp, B sweep, A sweep, B trigger, A trigger, trigger status.
- R9: Any other qualified address in 0800–0FFF raises only `no_dev`.
- R10: After a qualified access, exactly one output is high. At no time is more than one output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| vma | input | 1 | Valid memory address |
| e | input | 1 | Bus enable phase |
| rw | input | 1 | 1 = read, 0 = write |
| rom0_cs | output | 1 | First ROM select |
| rom1_cs | output | 1 | Second ROM select |
| ram_oe | output | 1 | RAM output enable |
| ram_we | output | 1 | RAM write enable |
| ctl_stb | output | 9 | Control strobes, bit layout per R6/R7 |
| page_stb | output | 16 | Per-address page strobes, bit order per R8 |
| no_dev | output | 1 | Qualified access to an undecoded address |

## Verification
The hardest situations to reach are the corners of the I/O overlay. These are the partial slot at 0824–082F, the per-sub-page off strobes that exist only at 0860/0960/0A60, and the page windows repeated in all eight sub-pages.

Random addresses rarely land on these. The stimulus therefore sweeps the whole 64 KB space twice, once for each bus direction, with the access qualified. Random traffic with `vma` and `e` toggled independently then shows that unqualified cycles stay silent. Directed cases hold one address while only the qualifiers change.

// File: rtl/addec_pkg.sv
package addec_pkg;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_ROM0 = 3'd2,
    RG_ROM1 = 3'd3,
    RG_IO   = 3'd4
  } region_e;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BLK_W    = 5;
  localparam int unsigned DMUX_N   = 3;
  localparam int unsigned PAGE_N   = 16;
  localparam int unsigned CTL_N    = 3 + 2 * DMUX_N;
  localparam int unsigned IO_OFF_W = ADDR_W - BLK_W + 1;

  // Map one 2 KB block number (top five address bits) to a region.
  function automatic region_e region_of(input logic [BLK_W-1:0] blk);
    region_e r;
    casez (blk)
      5'b100??: r = RG_RAM;
      5'b101??: r = RG_ROM0;
      5'b11???: r = RG_ROM1;
      5'b00000: r = RG_RAM;
      5'b00001: r = RG_IO;
      5'b0001?: r = RG_ROM0;
      default:  r = RG_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/addec_region.sv
module addec_region
  import addec_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BLK_W
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  logic [BW-1:0] blk;
  assign blk    = addr[AW-1 -: BW];
  assign region = region_of(blk);
endmodule

// File: rtl/addec_io.sv
module addec_io
  import addec_pkg::*;
#(
  parameter int unsigned NDM = DMUX_N,
  parameter int unsigned NPG = PAGE_N,
  localparam int unsigned NCTL = 3 + 2 * NDM
) (
  input  logic [11:0]     off,
  output logic [NCTL-1:0] ctl,
  output logic [NPG-1:0]  page,
  output logic            hit
);
  logic [3:0] sub;
  logic [3:0] slot;
  logic [3:0] low;
  logic       base_pg;
  logic       page_win;

  assign sub      = off[11:8];
  assign slot     = off[7:4];
  assign low      = off[3:0];
  assign base_pg  = (sub == 4'h8);
  assign page_win = sub[3] && (slot == 4'h7);

  assign ctl[0] = base_pg && (slot == 4'h0);
  assign ctl[1] = base_pg && (slot == 4'h1);
  assign ctl[2] = base_pg && (slot == 4'h2) && (low[3:2] == 2'b00);

  for (genvar i = 0; i < NDM; i++) begin : g_dmux
    assign ctl[3 + i]       = base_pg && (slot == 4'(3 + i));
    assign ctl[3 + NDM + i] = (sub == 4'(8 + i)) && (slot == 4'h6);
  end

  for (genvar j = 0; j < NPG; j++) begin : g_page
    assign page[j] = page_win && (low == 4'(j));
  end

  assign hit = (|ctl) || (|page);

  // R10
  always_comb begin
    if (!$isunknown(off)) begin
      io_excl_chk: assert ($onehot0({ctl, page}));
    end
  end
endmodule

// File: rtl/addec_ram_ctl.sv
module addec_ram_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rw,
  output logic oe,
  output logic we
);
  logic act_q;
  logic rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rw_q  <= 1'b1;
    end else begin
      act_q <= req;
      rw_q  <= rw;
    end
  end

  assign oe = act_q && rw_q;
  assign we = act_q && !rw_q;

  // R2
  ram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!oe && !we));
  // R3
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rw) |=> (we && !oe));
  // R3
  ram_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && rw) |=> (oe && !we));
endmodule

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import addec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              vma,
  input  logic              e,
  input  logic              rw,
  output logic              rom0_cs,
  output logic              rom1_cs,
  output logic              ram_oe,
  output logic              ram_we,
  output logic [CTL_N-1:0]  ctl_stb,
  output logic [PAGE_N-1:0] page_stb,
  output logic              no_dev
);
  logic              qual;
  region_e           region;
  logic [CTL_N-1:0]  io_ctl;
  logic [PAGE_N-1:0] io_page;
  logic              io_hit;
  logic              ram_req;
  logic              miss;

  assign qual = vma && e;

  addec_region #(.AW(ADDR_W), .BW(BLK_W)) u_region (
    .addr   (addr),
    .region (region)
  );

  addec_io #(.NDM(DMUX_N), .NPG(PAGE_N)) u_io (
    .off  (addr[11:0]),
    .ctl  (io_ctl),
    .page (io_page),
    .hit  (io_hit)
  );

  assign ram_req = qual && (region == RG_RAM);
  assign miss    = qual && ((region == RG_NONE) || ((region == RG_IO) && !io_hit));

  addec_ram_ctl u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ram_req),
    .rw    (rw),
    .oe    (ram_oe),
    .we    (ram_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom0_cs  <= 1'b0;
      rom1_cs  <= 1'b0;
      ctl_stb  <= '0;
      page_stb <= '0;
      no_dev   <= 1'b0;
    end else begin
      rom0_cs  <= qual && (region == RG_ROM0);
      rom1_cs  <= qual && (region == RG_ROM1);
      ctl_stb  <= (qual && (region == RG_IO)) ? io_ctl  : '0;
      page_stb <= (qual && (region == RG_IO)) ? io_page : '0;
      no_dev   <= miss;
    end
  end

  logic [CTL_N+PAGE_N+4:0] all_out;
  assign all_out = {rom0_cs, rom1_cs, ram_oe, ram_we, ctl_stb, page_stb, no_dev};

  // R10
  one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_out));
  // R10
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> ($countones(all_out) == 1));
  // R2
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (all_out == '0));
  // R4
  rom_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && addr[15] && addr[14]) |=> rom1_cs);
  // R5
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !addr[15] && (addr[14] || addr[13])) |=> no_dev);
endmodule

// File: tb/sim_mmio_addr_decode.sv
module sim_mmio_addr_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        vma = 1'b0;
  logic        e = 1'b0;
  logic        rw = 1'b1;
  logic        rom0_cs, rom1_cs, ram_oe, ram_we, no_dev;
  logic [8:0]  ctl_stb;
  logic [15:0] page_stb;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mmio_addr_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .vma(vma), .e(e), .rw(rw),
    .rom0_cs(rom0_cs), .rom1_cs(rom1_cs), .ram_oe(ram_oe), .ram_we(ram_we),
    .ctl_stb(ctl_stb), .page_stb(page_stb), .no_dev(no_dev)
  );

  // Expected layout: {no_dev, rom0, rom1, oe, we, ctl[8:0], page[15:0]}
  function automatic logic [29:0] model(input int a, input bit v, input bit en, input bit r);
    logic [29:0] x = '0;
    int hi, lo;
    if (!(v && en)) return x;
    hi = a / 256;
    lo = a % 256;
    if (a <= 'h07FF || (a >= 'h8000 && a <= 'h9FFF)) begin
      if (r) x[26] = 1'b1; else x[25] = 1'b1;
    end else if ((a >= 'h1000 && a <= 'h1FFF) || (a >= 'hA000 && a <= 'hBFFF)) x[28] = 1'b1;
    else if (a >= 'hC000) x[27] = 1'b1;
    else if (a >= 'h0800 && a <= 'h0FFF) begin
      if (lo >= 'h70 && lo <= 'h7F) x[a % 16] = 1'b1;
      else if (hi == 8 && lo < 'h60) begin
        if (lo / 16 == 2 && lo > 'h23) x[29] = 1'b1;
        else x[16 + lo / 16] = 1'b1;
      end else if (lo >= 'h60 && lo <= 'h6F && hi <= 'h0A) x[16 + 6 + hi - 8] = 1'b1;
      else x[29] = 1'b1;
    end else x[29] = 1'b1;
    return x;
  endfunction

  function automatic string tag_of(input int a, input bit v, input bit en);
    int lo = a % 256;
    if (!(v && en)) return "R2";
    if (a <= 'h07FF || (a >= 'h8000 && a <= 'h9FFF)) return "R3";
    if (a >= 'h1000 && a <= 'h1FFF) return "R4";
    if (a >= 'hA000) return "R4";
    if (a >= 'h2000) return "R5";
    if (lo >= 'h70 && lo <= 'h7F) return "R8";
    if (lo >= 'h60 && lo <= 'h6F) return "R7";
    if (a < 'h0860) return "R6";
    return "R9";
  endfunction

  function automatic logic [29:0] observed();
    return {no_dev, rom0_cs, rom1_cs, ram_oe, ram_we, ctl_stb, page_stb};
  endfunction

  task automatic check(input string tag, input logic [29:0] exp);
    logic [29:0] got = observed();
    n_chk++;
    if (got !== exp || $countones(got) > 1) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, addr, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, compare at the next falling edge.
  task automatic step(input int a, input bit v, input bit en, input bit r);
    logic [29:0] exp = model(a, v, en, r);
    string t = tag_of(a, v, en);
    addr = 16'(a); vma = v; e = en; rw = r;
    @(negedge clk);
    check(t, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2467));
    addr = 16'h8000; vma = 1'b1; e = 1'b1; rw = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", '0);
    @(negedge clk);
    rst_n = 1'b1;
    vma = 1'b0;
    @(negedge clk);
    check("R1", '0);

    // Directed corners
    step('h0823, 1, 1, 1);   // R6 last front-panel address
    step('h0824, 1, 1, 1);   // R9 hole in the partial slot
    step('h0960, 1, 1, 0);   // R7
    step('h0B60, 1, 1, 0);   // R9 no off strobe in this sub-page
    step('h0F7F, 1, 1, 1);   // R8 trigger status alias
    step('h8000, 1, 0, 0);   // R2 E low
    step('h8000, 0, 1, 0);   // R2 VMA low
    step('h8000, 1, 1, 0);   // R3 write
    step('h07FF, 1, 1, 1);   // R3 read alias
    step('h1000, 1, 1, 1);   // R4 alias
    step('h7FFF, 1, 1, 1);   // R5
    step('hFFFF, 1, 1, 0);   // R4 second ROM

    // Full sweep, both directions, qualified (R3..R10)
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a < 65536; a++) step(a, 1, 1, d[0]);
    end

    // Random traffic with independent qualifiers (R2, R10)
    for (int k = 0; k < 20000; k++) begin
      int unsigned ra = $urandom;
      int unsigned rb = $urandom;
      step(int'(ra % 65536), rb[0], rb[1], rb[2]);
    end

    // Reset mid-stream (R1)
    addr = 16'h0A70; vma = 1'b1; e = 1'b1; rw = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", '0);
    @(negedge clk);
    check("R1", '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule